// File: doc/BRIEF.md
# Reset Combiner with Cause Flags

This block merges six reset requests into one system reset and keeps a record of which requests caused it. The requests are a power-on detect, a brownout detect, a watchdog timeout, a software reset strobe, a serial-line break strobe, and a shared pin. The shared pin serves either as an active-low reset input or as a plain digital input. A configuration bit chooses between the two, but from power-on until the first reset release the pin always acts as a reset input.

The system reset asserts at once, without waiting for a clock edge, whenever any request is active. It stays asserted for a parameterised number of clock edges after the last request goes away, and it drops in step with the clock. The cause register holds one sticky flag per source. A power-on loads it with the power-on and brownout flags only. Every other reset adds its own flag, so causes build up until software clears them. Software clears a flag by writing 0 to its bit. Writing 1 to a bit leaves that flag as it was.

When the pin works as an input, it passes through a two-flop synchronizer and is presented as a general input. It never touches reset in that mode. All control and status pins are plain levels, so the block has no streaming interface and no back-pressure.

Top module: `rstc_top`

## Requirements
- R1: `sys_rst` goes to 1 without waiting for a clock edge whenever any of these is true: `por_req`, `bod_req`, `wdt_req`, `swr_req`, `brk_req`, or the pin acting as a reset input while `pin_io` is 0.
- R2: Once every request is inactive, `sys_rst` falls at the HOLD-th rising clock edge (default 16) and at no other time. With inputs changing between edges, this gives HOLD-1 post-edge samples at 1.
- R3: After the power-on phase, `pin_mode_rst` = 1 makes a low `pin_io` assert reset. `pin_mode_rst` = 0 means `pin_io` has no effect on `sys_rst`.
- R4: From `por_req` until the first fall of `sys_rst` (the power-on phase), the pin acts as a reset input whatever `pin_mode_rst` says. Holding `pin_io` low keeps `sys_rst` at 1.
- R5: A reset from any other source does not start a power-on phase. With `pin_mode_rst` = 0, a low `pin_io` during or after a watchdog reset has no effect on reset.
- R6: While `por_req` is active, `cause` is 6'b000011. Bit 0 is the power-on flag and bit 1 is the brownout flag.
- R7: Every other source sets its own flag and leaves the rest unchanged: bit 1 for brownout, bit 2 for watchdog, bit 3 for software, bit 4 for break, bit 5 for the pin. A flag sets at the first clock edge at which its source is active. The pin flag sets from the synchronized pin when the pin is low in reset mode outside the power-on phase.
- R8: On a clock edge with `clr_we` = 1, each `cause` bit whose `clr_data` bit is 0 clears. Each bit whose `clr_data` bit is 1 keeps its value.
- R9: A source that is active on the same edge as a clearing write keeps its flag set.
- R10: `pin_gpi` equals `pin_io` delayed by two clock edges while the pin is in input mode. It reads 1 while the pin acts as a reset input.
- R11: A low `pin_io` during the power-on phase does not set the pin flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on detect, active high, asynchronous |
| bod_req | input | 1 | Brownout detect, active high |
| wdt_req | input | 1 | Watchdog timeout, active high |
| swr_req | input | 1 | Software reset strobe, active high |
| brk_req | input | 1 | Serial break-detect strobe, active high |
| pin_mode_rst | input | 1 | Pin function: 1 reset input, 0 digital input |
| pin_io | input | 1 | Shared pin level (active low when used as reset) |
| clr_we | input | 1 | Cause register write strobe |
| clr_data | input | 6 | Write data: 0 clears a flag, 1 keeps it |
| sys_rst | output | 1 | Stretched system reset, active high |
| pin_gpi | output | 1 | Synchronized pin value for general input |
| cause | output | 6 | Per-source reset cause flags |

## Verification
A plain power-on is run first and measures the length of the stretch. A second power-on holds the pin low throughout, which separates the power-on override from the configured pin mode and shows that this phase does not raise the pin flag. Single-cycle strobes from watchdog, software, break and brownout show whether flags accumulate or overwrite one another. A low pin after a watchdog reset shows that no override is left over from that reset. Clearing writes with mixed data, and a clear that coincides with a strobe, show the bitwise clear rule and the priority of set over clear. Pin toggling in both modes checks both the synchronizer delay and the masking.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CAUSE_W = 6;
  localparam int B_POR = 0;
  localparam int B_BOD = 1;
  localparam int B_WDT = 2;
  localparam int B_SWR = 3;
  localparam int B_BRK = 4;
  localparam int B_PIN = 5;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t POR_CAUSE = cause_t'((1 << B_POR) | (1 << B_BOD));
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int  STAGES = 2,
  parameter bit  INIT   = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= {STAGES{INIT}};
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic por_req,
  input  logic src_any,
  output logic sys_rst,
  output logic por_phase
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt;
  logic             last_edge;

  // load on any request, count down once all are gone
  always_ff @(posedge clk or posedge src_any) begin
    if (src_any) begin
      cnt     <= CNT_W'(HOLD);
      sys_rst <= 1'b1;
    end else if (cnt != '0) begin
      cnt     <= cnt - 1'b1;
      sys_rst <= (cnt > CNT_W'(1));
    end
  end

  assign last_edge = (cnt == CNT_W'(1)) && !src_any;

  // power-on phase ends with the first reset release
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)        por_phase <= 1'b1;
    else if (last_edge) por_phase <= 1'b0;
  end
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic   clk,
  input  logic   por_req,
  input  cause_t set_vec,
  input  logic   clr_we,
  input  cause_t clr_data,
  output cause_t cause
);
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_flag
    always_ff @(posedge clk or posedge por_req) begin
      if (por_req)                     cause[i] <= POR_CAUSE[i];
      else if (set_vec[i])             cause[i] <= 1'b1;
      else if (clr_we && !clr_data[i]) cause[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int HOLD = 16
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               bod_req,
  input  logic               wdt_req,
  input  logic               swr_req,
  input  logic               brk_req,
  input  logic               pin_mode_rst,
  input  logic               pin_io,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_data,
  output logic               sys_rst,
  output logic               pin_gpi,
  output logic [CAUSE_W-1:0] cause
);
  logic   por_phase;
  logic   pin_is_rst;
  logic   pin_sync;
  logic   src_any;
  cause_t set_vec;

  assign pin_is_rst = pin_mode_rst | por_phase;
  assign src_any    = por_req | bod_req | wdt_req | swr_req | brk_req
                    | (pin_is_rst & ~pin_io);

  rstc_sync #(.STAGES(2), .INIT(1'b1)) u_pin_sync (
    .clk  (clk),
    .arst (por_req),
    .d    (pin_io),
    .q    (pin_sync)
  );

  rstc_stretch #(.HOLD(HOLD)) u_stretch (
    .clk       (clk),
    .por_req   (por_req),
    .src_any   (src_any),
    .sys_rst   (sys_rst),
    .por_phase (por_phase)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_BOD] = bod_req;
    set_vec[B_WDT] = wdt_req;
    set_vec[B_SWR] = swr_req;
    set_vec[B_BRK] = brk_req;
    set_vec[B_PIN] = pin_mode_rst & ~por_phase & ~pin_sync;
  end

  rstc_cause u_cause (
    .clk      (clk),
    .por_req  (por_req),
    .set_vec  (set_vec),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .cause    (cause)
  );

  assign pin_gpi = pin_is_rst ? 1'b1 : pin_sync;
endmodule

// File: rtl/rstc_sva.sv
module rstc_sva (
  input logic       clk,
  input logic       por_req,
  input logic       bod_req,
  input logic       wdt_req,
  input logic       swr_req,
  input logic       brk_req,
  input logic       pin_mode_rst,
  input logic       pin_io,
  input logic       clr_we,
  input logic [5:0] clr_data,
  input logic       sys_rst,
  input logic       pin_gpi,
  input logic [5:0] cause
);
  logic req_any;
  assign req_any = bod_req | wdt_req | swr_req | brk_req;

  AST_SRC_RESET: assert property (@(posedge clk) disable iff (por_req)
    (req_any || (pin_mode_rst && !pin_io)) |-> sys_rst); // R1
  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> !$past(req_any)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_req)
    !clr_we |=> ((cause & $past(cause)) == $past(cause))); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (por_req)
    (clr_we && !clr_data[3] && !swr_req) |=> !cause[3]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (por_req)
    (clr_we && wdt_req) |=> cause[2]); // R9
  AST_GPI_MASK: assert property (@(posedge clk) disable iff (por_req)
    pin_mode_rst |-> pin_gpi); // R10
endmodule

bind rstc_top rstc_sva u_sva (
  .clk          (clk),
  .por_req      (por_req),
  .bod_req      (bod_req),
  .wdt_req      (wdt_req),
  .swr_req      (swr_req),
  .brk_req      (brk_req),
  .pin_mode_rst (pin_mode_rst),
  .pin_io       (pin_io),
  .clr_we       (clr_we),
  .clr_data     (clr_data),
  .sys_rst      (sys_rst),
  .pin_gpi      (pin_gpi),
  .cause        (cause)
);

// File: tb/rstc_top_tb.sv
module rstc_top_tb;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       por_req, bod_req, wdt_req, swr_req, brk_req;
  logic       pin_mode_rst, pin_io, clr_we;
  logic [5:0] clr_data;
  logic       sys_rst, pin_gpi;
  logic [5:0] cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rstc_top #(.HOLD(HOLD)) u_dut (
    .clk(clk), .por_req(por_req), .bod_req(bod_req), .wdt_req(wdt_req),
    .swr_req(swr_req), .brk_req(brk_req), .pin_mode_rst(pin_mode_rst),
    .pin_io(pin_io), .clr_we(clr_we), .clr_data(clr_data),
    .sys_rst(sys_rst), .pin_gpi(pin_gpi), .cause(cause)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  int m_cnt = 0;
  bit m_rst = 1'b0, m_phase = 1'b0, m_s1 = 1'b1, m_s2 = 1'b1;
  bit [5:0] m_cause = '0;

  always @(posedge clk) begin
    bit src;
    bit [5:0] setv;
    if (por_req) begin
      m_cause = 6'b000011; m_cnt = HOLD; m_rst = 1'b1; m_phase = 1'b1;
      m_s1 = 1'b1; m_s2 = 1'b1;
    end else begin
      src = bod_req | wdt_req | swr_req | brk_req
          | (!pin_io && (pin_mode_rst || m_phase));
      setv = {pin_mode_rst && !m_phase && !m_s2, brk_req, swr_req,
              wdt_req, bod_req, 1'b0};
      if (clr_we) m_cause = (m_cause & clr_data) | setv;
      else        m_cause = m_cause | setv;
      if (src) begin
        m_cnt = HOLD; m_rst = 1'b1;
      end else if (m_cnt != 0) begin
        if (m_cnt == 1) m_phase = 1'b0;
        m_rst = (m_cnt > 1);
        m_cnt = m_cnt - 1;
      end
      m_s2 = m_s1; m_s1 = pin_io;
    end
    #2;
    if (!done) begin
      check("R2 sys_rst vs model", sys_rst, m_rst);
      check("R7 cause vs model", cause, m_cause);
      check("R10 pin_gpi vs model",
            pin_gpi, (pin_mode_rst || m_phase) ? 1 : m_s2);
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi;
    por_req = 1'b1; bod_req = 0; wdt_req = 0; swr_req = 0; brk_req = 0;
    pin_mode_rst = 0; pin_io = 1; clr_we = 0; clr_data = '1;
    edges(3);
    check("R6 reset cause", cause, 6'b000011);
    check("R1 por asserts reset", sys_rst, 1);
    por_req = 1'b0;
    hi = 0;
    repeat (40) begin @(posedge clk); #2; if (sys_rst) hi++; end
    check("R2 stretch length", hi, HOLD - 1);
    check("R6 flags after power-on", cause, 6'b000011);

    // power-on with the pin held low in input mode
    @(negedge clk); por_req = 1'b1; pin_io = 1'b0;
    edges(3); por_req = 1'b0;
    edges(30);
    check("R4 pin holds reset in power-on", sys_rst, 1);
    check("R11 no pin flag in power-on", cause, 6'b000011);
    pin_io = 1'b1;
    edges(20);
    check("R4 release after pin high", sys_rst, 0);

    // input mode toggling
    pin_io = 1'b0; edges(5);
    check("R3 input mode no reset", sys_rst, 0);
    check("R10 gpi follows pin", pin_gpi, 0);
    pin_io = 1'b1; edges(3);
    check("R10 gpi follows pin high", pin_gpi, 1);

    // watchdog then low pin: no override
    wdt_req = 1'b1; #1;
    check("R1 watchdog asserts at once", sys_rst, 1);
    @(negedge clk); wdt_req = 1'b0; pin_io = 1'b0;
    edges(20);
    check("R5 no override after watchdog", sys_rst, 0);
    check("R7 watchdog flag", cause, 6'b000111);
    pin_io = 1'b1;

    swr_req = 1'b1; @(negedge clk); swr_req = 1'b0; edges(3);
    brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; edges(20);
    check("R7 flags accumulate", cause, 6'b011111);

    clr_we = 1'b1; clr_data = 6'b111110; @(negedge clk); clr_we = 1'b0;
    check("R8 write clears zero bits only", cause, 6'b011110);
    clr_we = 1'b1; clr_data = 6'b000000; brk_req = 1'b1;
    @(negedge clk); clr_we = 1'b0; brk_req = 1'b0; clr_data = '1;
    check("R9 set beats clear", cause, 6'b010000);
    edges(20);

    // reset mode pin
    pin_mode_rst = 1'b1; pin_io = 1'b0;
    @(posedge clk); #2;
    check("R3 reset mode pin asserts", sys_rst, 1);
    check("R10 gpi masked in reset mode", pin_gpi, 1);
    edges(5); pin_io = 1'b1; edges(20);
    check("R7 pin flag", cause, 6'b110000);
    check("R3 released after pin high", sys_rst, 0);
    pin_mode_rst = 1'b0;

    bod_req = 1'b1; @(negedge clk); bod_req = 1'b0; edges(20);
    check("R7 brownout flag", cause, 6'b110010);

    @(negedge clk); por_req = 1'b1; edges(2);
    check("R6 power-on clears other flags", cause, 6'b000011);
    por_req = 1'b0; edges(20);
    check("R6 flags kept after release", cause, 6'b000011);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule